// File: doc/BRIEF.md
# Multicycle Accumulator Instruction Sequencer

This block is the control sequencer and register set of a small accumulator machine. It runs one instruction at a time. Each instruction is fetched from a single-port memory through explicit register transfers: the program counter goes into the address register, the memory is read, the word is captured in the data register, and the data register is copied into the instruction register. The block then decodes the instruction, resolves an operand address and executes. It handles arithmetic and logic operations, loads, stores, an unconditional jump and a branch on zero, a halt, and interrupt entry and return.

Memory sits outside the block. It is a plain synchronous array: a word read with `mem_rd` and `mem_addr` at one clock edge appears on `mem_rdata` during the next cycle, and a write with `mem_wr` takes effect at the edge. The data register serves both directions. It captures read data, and during a store it drives `mem_wdata`.

Instructions are 16 bits wide. The opcode is in [15:12], the addressing mode in [11:10], and the address or offset field in [9:0]. The accumulator is 16 bits and addresses are 10 bits.

Top module: `fde_sequencer`

## Requirements
- R1: After reset, `pc` is RESET_PC (default 0), `acc` is 0, the stack pointer is STACK_INIT (default 0x3F0), `halted`, `irq_ack`, `mem_rd` and `mem_wr` are all low, and the first state is the start of a fetch.
- R2: Every instruction starts with five cycles. Cycle 1 copies `pc` into the address register, with no strobe. Cycle 2 asserts `mem_rd` at address `pc`. Cycle 3 captures the word and increments `pc` by exactly one. Cycle 4 copies the word into the instruction register. Cycle 5 decodes. No strobe is asserted in cycles 3 to 5.
- R3: The opcodes are 0 ADD, 1 SUB, 2 AND, 3 OR, 4 LOAD, 5 STORE, 6 JMP, 7 BRZ, 8 HALT and 9 RETI. Codes 10 to 15 do nothing and take five cycles. For the data ops 0 to 4, the operand is read in the cycle after the address is known. The accumulator is updated two cycles later with acc+m, acc-m, acc&m, acc|m or m, modulo 2^16.
- R4: Mode 0 (direct) uses the field as the effective address. Mode 2 (PC-relative) uses the incremented `pc` plus the field, modulo 1024, so the field acts as a signed offset.
- R5: Mode 1 (indirect) spends three extra cycles: a read at the field address, a capture cycle, and an address load. The low 10 bits of the word read become the effective address.
- R6: Mode 3 (stack) takes the operand of a data op from the stack-pointer address and then increments the pointer. A STORE in mode 3 writes at pointer−1 and decrements the pointer. JMP and BRZ in mode 3 use the pointer as their target and leave it unchanged.
- R7: A STORE produces exactly one `mem_wr` cycle, at the effective address, with `mem_wdata` equal to `acc`. `mem_rd` and `mem_wr` are never high together, and memory is written at no other time.
- R8: JMP loads `pc` with the effective address. BRZ does the same only when `acc` is zero. Otherwise `pc` keeps the incremented value. A jump takes one execute cycle after the address is resolved.
- R9: HALT leaves `pc` at the address of the HALT word and raises `halted`. While halted, `pc` holds and no strobe is issued, until reset or an accepted interrupt.
- R10: `irq` is sampled only at the first cycle of a fetch, or in any halted cycle, and only while no service routine is active. Accepting it takes one cycle: it saves `pc`, loads `pc` with IRQ_VEC (default 0x200), marks the service as active, and pulses `irq_ack` high for one cycle, in the following cycle. While the service is active, `irq` is ignored.
- R11: RETI restores the saved `pc` and ends the service. An interrupt taken while halted therefore returns to the HALT word, which runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Level interrupt request |
| mem_rdata | input | 16 | Read data, valid in the cycle after a read strobe |
| mem_addr | output | 10 | Memory address (address register) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (data register) |
| irq_ack | output | 1 | One-cycle pulse after interrupt entry |
| halted | output | 1 | High while stopped by HALT |
| pc | output | 10 | Program counter |
| acc | output | 16 | Accumulator |

## Verification
The hard cases are cycles where an accepted interrupt coincides with an instruction boundary that has just changed `pc` in some other way: a taken jump or branch, a RETI, or a HALT that rewound `pc`. In each case the saved return address must be the redirected value, not the sequential one. These coincidences are provoked with a train of short `irq` pulses whose spacing drifts against the period of a countdown loop, so that successive pulses land on different instructions. A long pulse overlaps a service routine to exercise masking, and a late pulse arrives while the block is halted. The bench model predicts every strobe, address, write value and acknowledge cycle by cycle. It also predicts `pc`, `acc` and `halted` at each boundary, and any misplaced return address shows up as a mismatch there.

// File: rtl/fde_sequencer.sv
module fde_sequencer #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  parameter logic [ADDR_W-1:0] IRQ_VEC = ADDR_W'(512),
  parameter logic [ADDR_W-1:0] STACK_INIT = ADDR_W'(1008),
  localparam int DATA_W = ADDR_W + 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              irq_ack,
  output logic              halted,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] acc
);

  typedef enum logic [3:0] {
    S_FMAR = 4'd0, S_FRD = 4'd1, S_FMDR = 4'd2, S_FCIR = 4'd3,
    S_DEC  = 4'd4, S_IRD = 4'd5, S_ILD  = 4'd6, S_EA   = 4'd7,
    S_ORD  = 4'd8, S_OLD = 4'd9, S_EXE  = 4'd10, S_WR  = 4'd11,
    S_HALT = 4'd12
  } state_t;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_AND  = 4'd2;
  localparam logic [3:0] OP_OR   = 4'd3;
  localparam logic [3:0] OP_LOAD = 4'd4;
  localparam logic [3:0] OP_STOR = 4'd5;
  localparam logic [3:0] OP_JMP  = 4'd6;
  localparam logic [3:0] OP_BRZ  = 4'd7;
  localparam logic [3:0] OP_HALT = 4'd8;
  localparam logic [3:0] OP_RETI = 4'd9;

  localparam logic [1:0] M_DIR = 2'd0;
  localparam logic [1:0] M_IND = 2'd1;
  localparam logic [1:0] M_REL = 2'd2;
  localparam logic [1:0] M_STK = 2'd3;

  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

  state_t state;
  logic [ADDR_W-1:0] mar, sp, epc;
  logic [DATA_W-1:0] mdr, cir;
  logic in_svc;

  logic [3:0] opc;
  logic [1:0] mode;
  logic [ADDR_W-1:0] fld, ea_base;
  logic is_store, is_xfer, take_irq;
  logic [DATA_W-1:0] alu;
  state_t after_ea;

  assign opc      = cir[DATA_W-1 -: 4];
  assign mode     = cir[ADDR_W+1:ADDR_W];
  assign fld      = cir[ADDR_W-1:0];
  assign is_store = (opc == OP_STOR);
  assign is_xfer  = (opc == OP_JMP) || (opc == OP_BRZ);
  assign take_irq = irq && !in_svc;
  assign after_ea = is_xfer ? S_EXE : (is_store ? S_WR : S_ORD);

  always_comb begin
    case (mode)
      M_REL:   ea_base = pc + fld;
      M_STK:   ea_base = is_store ? sp - ONE_A : sp;
      default: ea_base = fld;
    endcase
  end

  always_comb begin
    case (opc)
      OP_ADD:  alu = acc + mdr;
      OP_SUB:  alu = acc - mdr;
      OP_AND:  alu = acc & mdr;
      OP_OR:   alu = acc | mdr;
      OP_LOAD: alu = mdr;
      default: alu = acc;
    endcase
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_rd    = (state == S_FRD) || (state == S_IRD) || (state == S_ORD);
  assign mem_wr    = (state == S_WR);
  assign halted    = (state == S_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_FMAR;
      pc      <= RESET_PC;
      mar     <= '0;
      mdr     <= '0;
      cir     <= '0;
      acc     <= '0;
      sp      <= STACK_INIT;
      epc     <= '0;
      in_svc  <= 1'b0;
      irq_ack <= 1'b0;
    end else begin
      irq_ack <= 1'b0;
      case (state)
        S_FMAR: begin
          if (take_irq) begin
            epc     <= pc;
            pc      <= IRQ_VEC;
            in_svc  <= 1'b1;
            irq_ack <= 1'b1;
          end else begin
            mar   <= pc;
            state <= S_FRD;
          end
        end
        S_FRD: state <= S_FMDR;
        S_FMDR: begin
          mdr   <= mem_rdata;
          pc    <= pc + ONE_A;
          state <= S_FCIR;
        end
        S_FCIR: begin
          cir   <= mdr;
          state <= S_DEC;
        end
        S_DEC: begin
          if (opc == OP_HALT) begin
            pc    <= pc - ONE_A;
            state <= S_HALT;
          end else if (opc == OP_RETI) begin
            pc     <= epc;
            in_svc <= 1'b0;
            state  <= S_FMAR;
          end else if (opc > OP_RETI) begin
            state <= S_FMAR;
          end else begin
            mar <= ea_base;
            if (mode == M_IND) begin
              state <= S_IRD;
            end else begin
              if (is_store) mdr <= acc;
              state <= after_ea;
            end
          end
        end
        S_IRD: state <= S_ILD;
        S_ILD: begin
          mdr   <= mem_rdata;
          state <= S_EA;
        end
        S_EA: begin
          mar <= mdr[ADDR_W-1:0];
          if (is_store) mdr <= acc;
          state <= after_ea;
        end
        S_ORD: state <= S_OLD;
        S_OLD: begin
          mdr   <= mem_rdata;
          state <= S_EXE;
        end
        S_EXE: begin
          if (is_xfer) begin
            if (opc == OP_JMP || acc == '0) pc <= mar;
          end else begin
            acc <= alu;
            if (mode == M_STK) sp <= sp + ONE_A;
          end
          state <= S_FMAR;
        end
        S_WR: begin
          if (mode == M_STK) sp <= sp - ONE_A;
          state <= S_FMAR;
        end
        S_HALT: begin
          if (take_irq) begin
            epc     <= pc;
            pc      <= IRQ_VEC;
            in_svc  <= 1'b1;
            irq_ack <= 1'b1;
            state   <= S_FMAR;
          end
        end
        default: state <= S_FMAR;
      endcase
    end
  end

endmodule

// File: rtl/fde_sequencer_chk.sv
module fde_sequencer_chk #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] IRQ_VEC = ADDR_W'(512),
  localparam int DATA_W = ADDR_W + 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_ack,
  input logic              halted,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] acc,
  input logic [ADDR_W-1:0] pc,
  input logic [3:0]        st
);

  localparam logic [3:0] ST_FMAR = 4'd0;
  localparam logic [3:0] ST_FMDR = 4'd2;

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_wr_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_wdata == acc);

  assert_fetch_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FMDR) |=> pc == $past(pc) + ADDR_W'(1));

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_rd && !mem_wr);

  assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |-> pc == $past(pc));

  assert_ack_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (pc == IRQ_VEC) && (st == ST_FMAR));

  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

endmodule

bind fde_sequencer fde_sequencer_chk #(.ADDR_W(ADDR_W), .IRQ_VEC(IRQ_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .halted(halted),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
  .acc(acc), .pc(pc), .st(state)
);

// File: tb/fde_sequencer_bench.sv
module fde_sequencer_bench;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam logic [AW-1:0] VEC = 10'h200;
  localparam logic [AW-1:0] SP0 = 10'h3F0;
  localparam int NCYC = 1800;

  logic clk = 1'b0;
  logic rst_n, irq;
  logic [DW-1:0] mem_rdata, mem_wdata, acc;
  logic [AW-1:0] mem_addr, pc;
  logic mem_rd, mem_wr, irq_ack, halted;

  always #5 clk = ~clk;

  fde_sequencer #(.ADDR_W(AW), .RESET_PC(10'h000), .IRQ_VEC(VEC), .STACK_INIT(SP0)) u_fde_sequencer (
    .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .irq_ack(irq_ack), .halted(halted), .pc(pc), .acc(acc)
  );

  logic [DW-1:0] mem [0:1023];
  logic [DW-1:0] mm  [0:1023];

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  typedef struct packed {
    logic rd; logic wr; logic ack; logic [AW-1:0] addr; logic [DW-1:0] wd;
  } ent_t;

  ent_t  eq[$];
  string tq[$];
  int n_chk = 0;
  int n_fail = 0;

  logic [AW-1:0] m_pc, m_sp, m_epc;
  logic [DW-1:0] m_acc;
  bit m_isr, m_halt, ack_pend;
  string m_tag;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ins(input int op, input int md, input int f);
    logic [3:0] o; logic [1:0] m; logic [9:0] a;
    o = op[3:0]; m = md[1:0]; a = f[9:0];
    return {o, m, a};
  endfunction

  task automatic put(input int a, input logic [DW-1:0] v);
    mem[a] = v;
    mm[a]  = v;
  endtask

  task automatic push(input logic rd, input logic wr, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input string t);
    ent_t e;
    e.rd = rd; e.wr = wr; e.ack = ack_pend; e.addr = a; e.wd = d;
    ack_pend = 1'b0;
    eq.push_back(e);
    tq.push_back(t);
  endtask

  task automatic model_step(input logic iv);
    logic [DW-1:0] w, v;
    logic [3:0] op;
    logic [1:0] md;
    logic [AW-1:0] f, ea;
    if (iv && !m_isr) begin
      push(1'b0, 1'b0, '0, '0, "R10");
      m_epc = m_pc; m_pc = VEC; m_isr = 1'b1; m_halt = 1'b0; ack_pend = 1'b1;
      m_tag = "R10";
      return;
    end
    if (m_halt) begin
      push(1'b0, 1'b0, '0, '0, "R9");
      m_tag = "R9";
      return;
    end
    w = mm[m_pc]; op = w[15:12]; md = w[11:10]; f = w[9:0];
    push(1'b0, 1'b0, '0, '0, "R2");
    push(1'b1, 1'b0, m_pc, '0, "R2");
    push(1'b0, 1'b0, '0, '0, "R2");
    push(1'b0, 1'b0, '0, '0, "R2");
    push(1'b0, 1'b0, '0, '0, "R3");
    m_pc = m_pc + 10'd1;
    m_tag = "R2";
    if (op == 4'd8) begin m_pc = m_pc - 10'd1; m_halt = 1'b1; m_tag = "R9"; return; end
    if (op == 4'd9) begin m_pc = m_epc; m_isr = 1'b0; m_tag = "R11"; return; end
    if (op > 4'd9) begin m_tag = "R3"; return; end
    case (md)
      2'd0: ea = f;
      2'd1: begin
        push(1'b1, 1'b0, f, '0, "R5");
        push(1'b0, 1'b0, '0, '0, "R5");
        push(1'b0, 1'b0, '0, '0, "R5");
        ea = mm[f][9:0];
      end
      2'd2: ea = m_pc + f;
      default: ea = (op == 4'd5) ? m_sp - 10'd1 : m_sp;
    endcase
    if (op == 4'd6 || op == 4'd7) begin
      push(1'b0, 1'b0, '0, '0, "R8");
      if (op == 4'd6 || m_acc == 16'd0) m_pc = ea;
      m_tag = "R8";
    end else if (op == 4'd5) begin
      push(1'b0, 1'b1, ea, m_acc, "R7");
      mm[ea] = m_acc;
      if (md == 2'd3) m_sp = m_sp - 10'd1;
      m_tag = "R7";
    end else begin
      push(1'b1, 1'b0, ea, '0, (md == 2'd3) ? "R6" : ((md == 2'd1) ? "R5" : "R4"));
      push(1'b0, 1'b0, '0, '0, "R3");
      push(1'b0, 1'b0, '0, '0, "R3");
      v = mm[ea];
      case (op)
        4'd0: m_acc = m_acc + v;
        4'd1: m_acc = m_acc - v;
        4'd2: m_acc = m_acc & v;
        4'd3: m_acc = m_acc | v;
        default: m_acc = v;
      endcase
      if (md == 2'd3) m_sp = m_sp + 10'd1;
      m_tag = "R3";
    end
  endtask

  function automatic logic irq_at(input int c);
    if (c >= 300 && c < 320) return 1'b1;
    if (c >= 1500 && c < 1504) return 1'b1;
    for (int k = 0; k < 10; k++)
      if (c >= 450 + 37 * k && c < 453 + 37 * k) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog: actual %0d expected %0d cycles at most", 100000, NCYC);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    ent_t e;
    string t;
    int bad;
    rst_n = 1'b0;
    irq = 1'b0;
    for (int i = 0; i < 1024; i++) begin mem[i] = '0; mm[i] = '0; end
    put(0,  ins(4, 0, 100));
    put(1,  ins(0, 0, 101));
    put(2,  ins(1, 1, 102));
    put(3,  ins(2, 2, 96));
    put(4,  ins(3, 2, 10'h3FC));
    put(5,  ins(5, 3, 0));
    put(6,  ins(4, 0, 104));
    put(7,  ins(7, 0, 9));
    put(8,  ins(8, 0, 0));
    put(9,  ins(15, 0, 0));
    put(10, ins(4, 3, 0));
    put(11, ins(7, 0, 8));
    put(12, ins(1, 0, 101));
    put(13, ins(5, 1, 105));
    put(14, ins(4, 0, 110));
    put(15, ins(1, 0, 106));
    put(16, ins(5, 0, 110));
    put(17, ins(7, 0, 19));
    put(18, ins(6, 2, 10'h3FB));
    put(19, ins(5, 3, 0));
    put(20, ins(8, 0, 0));
    put(100, 16'd5); put(101, 16'd3); put(102, 16'd103); put(103, 16'd2);
    put(104, 16'd0); put(105, 16'd200); put(106, 16'd1); put(110, 16'd20);
    put(512, ins(5, 0, 121));
    put(513, ins(4, 0, 120));
    put(514, ins(0, 0, 106));
    put(515, ins(5, 0, 120));
    put(516, ins(4, 0, 121));
    put(517, ins(9, 0, 0));
    m_pc = '0; m_sp = SP0; m_epc = '0; m_acc = '0;
    m_isr = 1'b0; m_halt = 1'b0; ack_pend = 1'b0; m_tag = "R1";

    repeat (3) @(negedge clk);
    chk("R1", "pc in reset", pc, 0);
    chk("R1", "acc in reset", acc, 0);
    chk("R1", "strobes rd/wr/ack in reset", {mem_rd, mem_wr, irq_ack}, 0);
    chk("R1", "halted in reset", halted, 0);
    rst_n = 1'b1;

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      irq = irq_at(cyc);
      if (eq.size() == 0) begin
        chk(m_tag, "pc at boundary", pc, m_pc);
        chk(m_tag, "acc at boundary", acc, m_acc);
        chk(m_tag, "halted at boundary", halted, m_halt);
        model_step(irq);
      end
      e = eq.pop_front();
      t = tq.pop_front();
      chk(t, "strobes rd/wr/ack", {mem_rd, mem_wr, irq_ack}, {e.rd, e.wr, e.ack});
      if (e.rd || e.wr) chk(t, "address", mem_addr, e.addr);
      if (e.wr) chk(t, "store data", mem_wdata, e.wd);
      @(negedge clk);
    end

    bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== mm[i]) bad++;
    chk("R7", "words differing from model memory", bad, 0);
    chk("R5", "indirect store target", mem[200], 16'h0062);
    chk("R6", "stack word after final push", mem[10'h3EF], 16'h0000);
    chk("R8", "loop counter at exit", mem[110], 0);
    chk("R10", "service routine ran", (mem[120] != 16'd0) ? 1 : 0, 1);
    chk("R9", "halted at end", halted, 1);
    chk("R11", "pc back on halt word", pc, 20);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule